// File: doc/BRIEF.md
# Configurable Input Capture Bank

This block conditions a set of pin-level inputs before they reach a programmable logic array. It holds two independent groups of cells, a dedicated-input group and an I/O-pin group, ten cells each by default. Every cell is set by its own two-bit mode code. The cell can pass its pin straight through. It can act as a transparent latch. It can also act as an edge-triggered register. Each cell drives its value in both true and complement form.

One shared capture signal serves all cells. A latch cell treats it as an enable, and a register cell treats it as its capture edge. The whole block runs on one system clock. The capture signal is sampled on that clock: its level drives the latches, and a low-to-high change between two samples marks a register capture. A test preload port writes any value into the storage of every cell, and it takes priority over normal capture. The mode codes are a static configuration vector. They may still be changed while the block runs.

Top module: `pin_capture_bank`

## Requirements
- R1: With mode code 2'b00 (pass) a cell's true output equals its pin in the same cycle, whatever the capture signal and the preload port do.
- R2: Mode code 2'b11 is invalid. The cell behaves as pass and sets its bit of the group's config-error output. Every other code leaves that bit low.
- R3: With mode code 2'b01 (latch), while the capture signal is high, the true output equals the current pin value.
- R4: In latch mode, while the capture signal is low, the true output holds the pin value from the last clock edge at which the capture signal was high, or the last preloaded value if that is later. Pin changes have no effect.
- R5: With mode code 2'b10 (register) the cell loads its pin at a clock edge where the capture signal is high and was low at the previous edge. At all other edges it keeps its value, even when the pin changes.
- R6: Each complement output is always the bitwise inverse of the matching true output.
- R7: When preload_en is high at a clock edge, every cell's storage loads its preload bit. A capture edge or a high latch enable in the same cycle is overridden.
- R8: Synchronous reset clears all cell storage to 0 and clears the remembered capture level to low. A capture signal that is high on the first cycle after reset therefore counts as a rising edge.
- R9: The two groups are configured independently. The same pin values and the same capture signal give results set only by each cell's own mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_clk | input | 1 | Shared capture signal (latch enable / register edge) |
| ded_pin | input | N_DED | Dedicated-group pin values |
| ded_mode | input | 2*N_DED | Dedicated-group mode codes, cell i at bits [2i+1:2i] |
| io_pin | input | N_IO | I/O-group pin values |
| io_mode | input | 2*N_IO | I/O-group mode codes, cell i at bits [2i+1:2i] |
| preload_en | input | 1 | Test preload strobe for all cells |
| ded_preload | input | N_DED | Preload values, dedicated group |
| io_preload | input | N_IO | Preload values, I/O group |
| ded_true | output | N_DED | Dedicated-group values, true form |
| ded_comp | output | N_DED | Dedicated-group values, complement form |
| io_true | output | N_IO | I/O-group values, true form |
| io_comp | output | N_IO | I/O-group values, complement form |
| ded_cfg_err | output | N_DED | Per-cell invalid mode flag, dedicated group |
| io_cfg_err | output | N_IO | Per-cell invalid mode flag, I/O group |

## Verification
A cell whose stored bit is wrong shows it on its true and complement outputs. In register mode this appears from the cycle after the faulty edge. In latch mode it appears from the first cycle the capture signal is low. While the capture signal stays high, a latch cell hides a bad stored value, so the bench drops the signal and holds the pin steady before it compares. A wrong remembered capture level shows as a register that loads one cycle late or loads twice. This is checked directly after reset and across a preload that collides with a rising edge.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_LATCH = 2'b01,
        MODE_REG   = 2'b10,
        MODE_BAD   = 2'b11
    } cap_mode_e;

    typedef struct packed {
        logic tru;
        logic cmp;
    } dual_rail_t;

    function automatic dual_rail_t make_rail(input logic v);
        dual_rail_t r;
        r.tru = v;
        r.cmp = ~v;
        return r;
    endfunction

    function automatic logic mode_invalid(input cap_mode_e m);
        return (m == MODE_BAD);
    endfunction

endpackage

// File: rtl/pcb_edge_detect.sv
module pcb_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic cap_lvl,
    output logic cap_rise
);
    logic cap_prev;

    always_ff @(posedge clk) begin
        if (rst) cap_prev <= 1'b0;
        else     cap_prev <= cap_lvl;
    end

    assign cap_rise = cap_lvl & ~cap_prev;

    AST_RISE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cap_rise |=> !cap_rise); // R5

endmodule

// File: rtl/pcb_cell.sv
module pcb_cell
    import pcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_lvl,
    input  logic       cap_rise,
    input  logic       pin,
    input  cap_mode_e  mode,
    input  logic       pl_en,
    input  logic       pl_val,
    output dual_rail_t rail,
    output logic       cfg_err
);
    logic held;
    logic take;
    logic value;

    always_comb begin
        unique case (mode)
            MODE_LATCH: take = cap_lvl;
            MODE_REG:   take = cap_rise;
            default:    take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        held <= 1'b0;
        else if (pl_en) held <= pl_val;
        else if (take)  held <= pin;
    end

    always_comb begin
        unique case (mode)
            MODE_LATCH: value = cap_lvl ? pin : held;
            MODE_REG:   value = held;
            default:    value = pin;
        endcase
    end

    assign rail    = make_rail(value);
    assign cfg_err = mode_invalid(mode);

    AST_REG_LOADS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG && cap_rise && !pl_en) |=> (held == $past(pin))); // R5
    AST_REG_KEEPS_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG && !cap_rise && !pl_en) |=> $stable(held)); // R5
    AST_LATCH_KEEPS_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH && !cap_lvl && !pl_en) |=> $stable(held)); // R4
    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        pl_en |=> (held == $past(pl_val))); // R7
    AST_BAD_CODE_PASSES: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BAD) |-> (rail.tru == pin && cfg_err)); // R2

endmodule

// File: rtl/pcb_group.sv
module pcb_group
    import pcb_pkg::*;
#(
    parameter int N_CELLS = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap_lvl,
    input  logic                   cap_rise,
    input  logic [N_CELLS-1:0]     pins,
    input  logic [2*N_CELLS-1:0]   modes,
    input  logic                   pl_en,
    input  logic [N_CELLS-1:0]     pl_vals,
    output logic [N_CELLS-1:0]     out_true,
    output logic [N_CELLS-1:0]     out_comp,
    output logic [N_CELLS-1:0]     cfg_err
);
    localparam int MODE_W = 2;

    dual_rail_t rails [N_CELLS];

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        pcb_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .cap_lvl  (cap_lvl),
            .cap_rise (cap_rise),
            .pin      (pins[i]),
            .mode     (cap_mode_e'(modes[MODE_W*i +: MODE_W])),
            .pl_en    (pl_en),
            .pl_val   (pl_vals[i]),
            .rail     (rails[i]),
            .cfg_err  (cfg_err[i])
        );
        assign out_true[i] = rails[i].tru;
        assign out_comp[i] = rails[i].cmp;
    end

endmodule

// File: rtl/pin_capture_bank.sv
module pin_capture_bank #(
    parameter int N_DED = 10,
    parameter int N_IO  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_clk,
    input  logic [N_DED-1:0]     ded_pin,
    input  logic [2*N_DED-1:0]   ded_mode,
    input  logic [N_IO-1:0]      io_pin,
    input  logic [2*N_IO-1:0]    io_mode,
    input  logic                 preload_en,
    input  logic [N_DED-1:0]     ded_preload,
    input  logic [N_IO-1:0]      io_preload,
    output logic [N_DED-1:0]     ded_true,
    output logic [N_DED-1:0]     ded_comp,
    output logic [N_IO-1:0]      io_true,
    output logic [N_IO-1:0]      io_comp,
    output logic [N_DED-1:0]     ded_cfg_err,
    output logic [N_IO-1:0]      io_cfg_err
);
    logic cap_rise;

    pcb_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .cap_lvl  (cap_clk),
        .cap_rise (cap_rise)
    );

    pcb_group #(.N_CELLS(N_DED)) u_ded (
        .clk      (clk),
        .rst      (rst),
        .cap_lvl  (cap_clk),
        .cap_rise (cap_rise),
        .pins     (ded_pin),
        .modes    (ded_mode),
        .pl_en    (preload_en),
        .pl_vals  (ded_preload),
        .out_true (ded_true),
        .out_comp (ded_comp),
        .cfg_err  (ded_cfg_err)
    );

    pcb_group #(.N_CELLS(N_IO)) u_io (
        .clk      (clk),
        .rst      (rst),
        .cap_lvl  (cap_clk),
        .cap_rise (cap_rise),
        .pins     (io_pin),
        .modes    (io_mode),
        .pl_en    (preload_en),
        .pl_vals  (io_preload),
        .out_true (io_true),
        .out_comp (io_comp),
        .cfg_err  (io_cfg_err)
    );

endmodule

// File: tb/pin_capture_bank_test.sv
`timescale 1ns/1ps
module pin_capture_bank_test;
    localparam int N = 10;
    // dedicated group: cells 0-1 pass, 2-4 latch, 5-8 register, 9 invalid
    localparam logic [2*N-1:0] DED_MODES = {2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
                                            2'b01, 2'b01, 2'b01, 2'b00, 2'b00};
    localparam logic [2*N-1:0] IO_ALL_REG  = {N{2'b10}};
    localparam logic [2*N-1:0] IO_ALL_PASS = {N{2'b00}};
    localparam logic [2*N-1:0] IO_ALL_BAD  = {N{2'b11}};

    typedef struct packed {
        logic         cap;
        logic [N-1:0] pin;
        logic         pl;
        logic [N-1:0] plv;
        logic [N-1:0] exp_ded;
        logic [N-1:0] exp_io;
    } step_t;

    localparam int STEPS = 10;
    localparam step_t TABLE [STEPS] = '{
        '{1'b0, 10'h3FF, 1'b0, 10'h000, 10'h203, 10'h000}, // R1 pass, R5 no edge
        '{1'b1, 10'h155, 1'b0, 10'h000, 10'h155, 10'h155}, // R3, R5 rising edge
        '{1'b1, 10'h2AA, 1'b0, 10'h000, 10'h34A, 10'h155}, // R3 transparent, R5 hold
        '{1'b0, 10'h3FF, 1'b0, 10'h000, 10'h34B, 10'h155}, // R4 latch holds
        '{1'b0, 10'h000, 1'b0, 10'h000, 10'h148, 10'h155}, // R4, R5 pin ignored
        '{1'b1, 10'h3FF, 1'b0, 10'h000, 10'h3FF, 10'h3FF}, // R5 second edge
        '{1'b0, 10'h000, 1'b1, 10'h0F0, 10'h0F0, 10'h0F0}, // R7 preload
        '{1'b1, 10'h3FF, 1'b1, 10'h000, 10'h21F, 10'h000}, // R7 preload beats edge
        '{1'b0, 10'h3FF, 1'b0, 10'h000, 10'h203, 10'h000}, // R7 latch kept preload
        '{1'b0, 10'h155, 1'b0, 10'h000, 10'h001, 10'h000}  // R1, R9
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_clk = 1'b0;
    logic [N-1:0] ded_pin = '0, io_pin = '0;
    logic [2*N-1:0] ded_mode = DED_MODES, io_mode = IO_ALL_REG;
    logic         preload_en = 1'b0;
    logic [N-1:0] ded_preload = '0, io_preload = '0;
    logic [N-1:0] ded_true, ded_comp, io_true, io_comp, ded_cfg_err, io_cfg_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pin_capture_bank uut (
        .clk(clk), .rst(rst), .cap_clk(cap_clk),
        .ded_pin(ded_pin), .ded_mode(ded_mode),
        .io_pin(io_pin), .io_mode(io_mode),
        .preload_en(preload_en), .ded_preload(ded_preload), .io_preload(io_preload),
        .ded_true(ded_true), .ded_comp(ded_comp),
        .io_true(io_true), .io_comp(io_comp),
        .ded_cfg_err(ded_cfg_err), .io_cfg_err(io_cfg_err)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic c, input logic [N-1:0] p, input logic pe, input logic [N-1:0] pv);
        @(negedge clk);
        cap_clk = c; ded_pin = p; io_pin = p; preload_en = pe; ded_preload = pv; io_preload = pv;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset clears register cells", io_true, '0);
        check("R6 complement during reset", io_comp, 10'h3FF);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < STEPS; k++) begin
            apply(TABLE[k].cap, TABLE[k].pin, TABLE[k].pl, TABLE[k].plv);
            check($sformatf("R9 dedicated group step %0d", k), ded_true, TABLE[k].exp_ded);
            check($sformatf("R5 io register group step %0d", k), io_true, TABLE[k].exp_io);
            check($sformatf("R6 complement step %0d", k), ded_comp, ~TABLE[k].exp_ded);
        end

        check("R2 dedicated config error flags", ded_cfg_err, 10'h200);
        check("R2 io config error flags", io_cfg_err, 10'h000);

        // R8: reset mid-run with capture high, then first cycle after counts as edge
        apply(1'b1, 10'h3FF, 1'b0, '0);
        check("R5 capture before reset", io_true, 10'h3FF);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R8 reset clears storage", io_true, '0);
        @(negedge clk);
        rst = 1'b0; io_pin = 10'h2AA; ded_pin = 10'h2AA;
        @(posedge clk);
        #2;
        check("R8 capture level cleared by reset", io_true, 10'h2AA);

        // R2: invalid codes pass through and flag
        @(negedge clk);
        io_mode = IO_ALL_BAD; cap_clk = 1'b0; io_pin = 10'h0C3;
        @(posedge clk);
        #2;
        check("R2 invalid code passes pin", io_true, 10'h0C3);
        check("R2 invalid code flags all cells", io_cfg_err, 10'h3FF);

        // R1: pass mode ignores preload and capture
        @(negedge clk);
        io_mode = IO_ALL_PASS; io_pin = 10'h21C; preload_en = 1'b1; io_preload = 10'h3FF; cap_clk = 1'b1;
        @(posedge clk);
        #2;
        check("R1 pass ignores preload and capture", io_true, 10'h21C);
        check("R6 complement in pass", io_comp, ~10'h21C);
        preload_en = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule